// File: doc/BRIEF.md
# Dual-Format Serial Audio Transceiver

This block moves stereo PCM samples between a parallel interface and a three-wire serial audio link made of a bit clock, a word select and a data line. The output port generates its own bit clock and word select from the system clock and serialises one left/right pair per frame. The input port takes a separate, externally driven bit clock, word select and data line. It brings them into the system clock domain, follows the word select, and rebuilds each left/right pair.

Two run-time controls shape the framing on both ports. The format control picks between standard I2S framing and LSB-justified framing. The length control picks a sample width of 16, 18 or 20 bits. Each channel occupies a half-frame of 32 bit clocks, so every width fits. Samples on the parallel side are right-aligned in a 20-bit field. The transmit side accepts a pair through a valid/ready handshake. The receive side presents each completed pair with a single-cycle valid strobe.

Top module: `serial_audio_xcvr`

## Requirements
- R1: While reset is asserted and right after it, sBclkOut is 0, sWsOut is 1, sDataOut is 0, txReady is 1 and rxValid is 0.
- R2: sBclkOut has a period of 2*DIV system clocks. Frame position p runs 0..63, advancing on each falling edge of sBclkOut. sWsOut is 0 (left) for p 0..31 and 1 (right) for p 32..63. sWsOut and sDataOut change only just after a falling edge of sBclkOut.
- R3: With fmtSel=0 (I2S), let k = p mod 32 and L be the word length. The bit at slot offset k is sample bit L-k for k in 1..L, so the MSB is at k=1. Every other bit is 0.
- R4: With fmtSel=1 (LSB-justified), the bit at slot offset k is sample bit 31-k when 31-k < L, so the LSB is at k=31. The leading positions carry 0.
- R5: lenSel 00 selects 16 bits, 01 selects 18 bits, and 10 or 11 select 20 bits. Transmit sample bits at or above the word length have no effect on sDataOut.
- R6: The transmitter holds one pending pair. txReady drops in the cycle after txValid is accepted. It returns to 1 when the pending pair is moved into the frame engine, at the rising bit-clock edge of position 63, and that pair is sent in the next frame.
- R7: If no pair is pending when a frame starts, that frame carries an all-zero left and right word.
- R8: The receiver samples sDataIn and sWsIn on rising edges of sBclkIn, using the same format and length controls. In I2S mode it takes slot offsets 1..L. In LSB-justified mode it takes the last L bits of each half. All other bits are ignored. The result is right-aligned and zero-extended to 20 bits.
- R9: rxValid pulses for exactly one cycle when a falling transition of sWsIn ends a right word, provided a complete left half came before it. rxLeft and rxRight hold that pair until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fmtSel | input | 1 | 0 = I2S framing, 1 = LSB-justified framing |
| lenSel | input | 2 | Word length select: 00 = 16, 01 = 18, 1x = 20 bits |
| txLeft | input | 20 | Left sample to send, right-aligned |
| txRight | input | 20 | Right sample to send, right-aligned |
| txValid | input | 1 | Transmit pair offered |
| txReady | output | 1 | Transmitter can take a pair |
| sBclkOut | output | 1 | Output port bit clock |
| sWsOut | output | 1 | Output port word select (0 = left) |
| sDataOut | output | 1 | Output port serial data |
| sBclkIn | input | 1 | Input port bit clock |
| sWsIn | input | 1 | Input port word select (0 = left) |
| sDataIn | input | 1 | Input port serial data |
| rxLeft | output | 20 | Last received left sample |
| rxRight | output | 20 | Last received right sample |
| rxValid | output | 1 | One-cycle strobe for a new received pair |

## Verification
The hardest case to reach is a receive stream whose padding positions carry ones rather than zeros. In loopback the transmitter only ever sends zeros in those slots, so loopback alone cannot show that the receiver ignores them. For that case the bench switches the input port off the loopback and drives its own bit clock, word select and data. It fills every padding slot with 1 in both formats and checks that the rebuilt pair is unaffected. A second hard-to-reach case is the handover between the pending register and the frame engine. To reach it, the bench offers pairs back-to-back and then stops, so that it sees the held-off handshake and the silent frame that follows.

// File: rtl/aud_pkg.sv
package aud_pkg;
  localparam int SLOT_BITS = 32;
  localparam int POS_W     = $clog2(2 * SLOT_BITS);
  localparam int K_W       = $clog2(SLOT_BITS);
  localparam int MAX_W     = 20;
  localparam int LEN_W     = $clog2(MAX_W + 1);

  typedef enum logic {FMT_I2S = 1'b0, FMT_LSBJ = 1'b1} fmt_e;

  // strobes passed from the timing control to the datapath
  typedef struct packed {
    logic             txFall;
    logic             loadFrame;
    logic [POS_W-1:0] txPosNext;
    logic             rxEdge;
    logic             rxWsChange;
    logic             rxPrevWs;
    logic [POS_W-1:0] rxK;
    logic             rxDat;
  } strobe_t;

  function automatic logic [LEN_W-1:0] wordLen(input logic [1:0] sel);
    case (sel)
      2'b00:   return LEN_W'(16);
      2'b01:   return LEN_W'(18);
      default: return LEN_W'(20);
    endcase
  endfunction
endpackage

// File: rtl/aud_ctrl.sv
module aud_ctrl
  import aud_pkg::*;
#(
  parameter int DIV = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sBclkIn,
  input  logic    sWsIn,
  input  logic    sDataIn,
  output logic    sBclkOut,
  output logic    sWsOut,
  output strobe_t st
);
  localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

  // transmit timing
  logic [DIV_W-1:0] divCnt;
  logic             bclkQ;
  logic             wsQ;
  logic [POS_W-1:0] pos;
  logic             tick;
  logic [POS_W-1:0] posNext;

  assign tick    = (divCnt == DIV_W'(DIV - 1));
  assign posNext = pos + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      bclkQ  <= 1'b0;
      wsQ    <= 1'b1;
      pos    <= '1;
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) bclkQ <= ~bclkQ;
      if (tick && bclkQ) begin
        pos <= posNext;
        wsQ <= posNext[POS_W-1];
      end
    end
  end

  assign sBclkOut = bclkQ;
  assign sWsOut   = wsQ;

  // receive synchronisers and word-select tracking
  logic [SYNC_STAGES-1:0] bSync, wSync, dSync;
  logic bPrev, wsLast;
  logic [POS_W-1:0] kCnt, kNext;
  logic bS, wS, dS, rxEdge, wsChange;

  assign bS       = bSync[SYNC_STAGES-1];
  assign wS       = wSync[SYNC_STAGES-1];
  assign dS       = dSync[SYNC_STAGES-1];
  assign rxEdge   = bS & ~bPrev;
  assign wsChange = (wS != wsLast);
  assign kNext    = wsChange ? '0 : ((kCnt == '1) ? kCnt : kCnt + 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bSync  <= '0;
      wSync  <= '0;
      dSync  <= '0;
      bPrev  <= 1'b0;
      wsLast <= 1'b0;
      kCnt   <= '0;
    end else begin
      bSync <= {bSync[SYNC_STAGES-2:0], sBclkIn};
      wSync <= {wSync[SYNC_STAGES-2:0], sWsIn};
      dSync <= {dSync[SYNC_STAGES-2:0], sDataIn};
      bPrev <= bS;
      if (rxEdge) begin
        wsLast <= wS;
        kCnt   <= kNext;
      end
    end
  end

  always_comb begin
    st.txFall     = tick & bclkQ;
    st.loadFrame  = tick & ~bclkQ & (pos == '1);
    st.txPosNext  = posNext;
    st.rxEdge     = rxEdge;
    st.rxWsChange = wsChange;
    st.rxPrevWs   = wsLast;
    st.rxK        = kNext;
    st.rxDat      = dS;
  end

  // R2: word select moves only together with a falling bit clock
  a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wsQ) |-> ($past(bclkQ) && !bclkQ));
endmodule

// File: rtl/aud_dp.sv
module aud_dp
  import aud_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic             fmtSel,
  input  logic [1:0]       lenSel,
  input  logic [MAX_W-1:0] txLeft,
  input  logic [MAX_W-1:0] txRight,
  input  logic             txValid,
  output logic             txReady,
  output logic             sDataOut,
  output logic [MAX_W-1:0] rxLeft,
  output logic [MAX_W-1:0] rxRight,
  output logic             rxValid
);
  logic [LEN_W-1:0] len;
  logic [MAX_W-1:0] lenMask;
  assign len = wordLen(lenSel);

  always_comb
    for (int i = 0; i < MAX_W; i++) lenMask[i] = (i < int'(len));

  // bit for slot offset k of a word, per format
  function automatic logic pickBit(input logic [K_W-1:0] kBits, input logic [MAX_W-1:0] w,
                                   input logic fmt, input logic [LEN_W-1:0] l);
    int k, idx;
    logic b;
    k = int'(kBits);
    b = 1'b0;
    if (fmt == FMT_I2S) idx = (k >= 1 && k <= int'(l)) ? int'(l) - k : -1;
    else idx = (SLOT_BITS - 1 - k < int'(l)) ? SLOT_BITS - 1 - k : -1;
    for (int i = 0; i < MAX_W; i++) if (i == idx) b = w[i];
    return b;
  endfunction

  logic [MAX_W-1:0] pendL, pendR, actL, actR;
  logic pendFull, dataQ, accept, txNextBit;

  assign accept    = txValid & ~pendFull;
  assign txReady   = ~pendFull;
  assign txNextBit = pickBit(st.txPosNext[K_W-1:0],
                             st.txPosNext[POS_W-1] ? actR : actL, fmtSel, len);

  logic [MAX_W-1:0] shiftQ, capL, outL, outR, captured;
  logic seenStart, leftOk, validQ, take;
  int   kInt;

  assign kInt     = int'(st.rxK);
  assign take     = (fmtSel == FMT_LSBJ) || (kInt >= 1 && kInt <= int'(len));
  assign captured = shiftQ & lenMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendL <= '0; pendR <= '0; pendFull <= 1'b0;
      actL <= '0; actR <= '0; dataQ <= 1'b0;
      shiftQ <= '0; capL <= '0; outL <= '0; outR <= '0;
      seenStart <= 1'b0; leftOk <= 1'b0; validQ <= 1'b0;
    end else begin
      validQ <= 1'b0;
      if (st.loadFrame) begin
        actL     <= pendFull ? pendL : '0;
        actR     <= pendFull ? pendR : '0;
        pendFull <= 1'b0;
      end
      if (accept) begin
        pendL    <= txLeft;
        pendR    <= txRight;
        pendFull <= 1'b1;
      end
      if (st.txFall) dataQ <= txNextBit;
      if (st.rxEdge) begin
        if (st.rxWsChange) begin
          seenStart <= 1'b1;
          if (!st.rxPrevWs) begin
            capL   <= captured;
            leftOk <= seenStart;
          end else begin
            if (leftOk) begin
              outL   <= capL;
              outR   <= captured;
              validQ <= 1'b1;
            end
            leftOk <= 1'b0;
          end
          shiftQ <= take ? {{(MAX_W-1){1'b0}}, st.rxDat} : '0;
        end else if (take) begin
          shiftQ <= {shiftQ[MAX_W-2:0], st.rxDat};
        end
      end
    end
  end

  assign sDataOut = dataQ;
  assign rxLeft   = outL;
  assign rxRight  = outR;
  assign rxValid  = validQ;

  // R2: serial data only moves after a falling bit-clock strobe
  a_r2_data_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataQ) |-> $past(st.txFall));
  // R6: ready drops only after a pair was offered
  a_r6_ready_falls_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txReady) |-> $past(txValid));
  // R7: an empty holding register yields a silent frame
  a_r7_silent_frame: assert property (@(posedge clk) disable iff (!rstN)
    (st.loadFrame && !pendFull) |=> (actL == '0 && actR == '0));
  // R9: single-cycle strobe, raised only by a right-to-left word-select change
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    validQ |=> !validQ);
  a_r9_valid_on_ws_fall: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> $past(st.rxEdge && st.rxWsChange && st.rxPrevWs));
endmodule

// File: rtl/serial_audio_xcvr.sv
module serial_audio_xcvr
  import aud_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fmtSel,
  input  logic [1:0]  lenSel,
  input  logic [19:0] txLeft,
  input  logic [19:0] txRight,
  input  logic        txValid,
  output logic        txReady,
  output logic        sBclkOut,
  output logic        sWsOut,
  output logic        sDataOut,
  input  logic        sBclkIn,
  input  logic        sWsIn,
  input  logic        sDataIn,
  output logic [19:0] rxLeft,
  output logic [19:0] rxRight,
  output logic        rxValid
);
  strobe_t st;

  aud_ctrl #(.DIV(DIV), .SYNC_STAGES(2)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .sBclkIn(sBclkIn), .sWsIn(sWsIn), .sDataIn(sDataIn),
    .sBclkOut(sBclkOut), .sWsOut(sWsOut), .st(st)
  );

  aud_dp dp_i (
    .clk(clk), .rstN(rstN), .st(st),
    .fmtSel(fmtSel), .lenSel(lenSel),
    .txLeft(txLeft), .txRight(txRight), .txValid(txValid), .txReady(txReady),
    .sDataOut(sDataOut),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );
endmodule

// File: tb/serial_audio_xcvr_tb_top.sv
`timescale 1ns/1ps
module serial_audio_xcvr_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fmtSel = 1'b0;
  logic [1:0] lenSel = 2'b00;
  logic [19:0] txLeft = '0, txRight = '0;
  logic txValid = 1'b0;
  logic useLoop = 1'b1;
  logic tbBclk = 1'b0, tbWs = 1'b0, tbDat = 1'b0;
  logic txReady, sBclkOut, sWsOut, sDataOut, rxValid;
  logic [19:0] rxLeft, rxRight;
  logic sBclkIn, sWsIn, sDataIn;

  assign sBclkIn = useLoop ? sBclkOut : tbBclk;
  assign sWsIn   = useLoop ? sWsOut   : tbWs;
  assign sDataIn = useLoop ? sDataOut : tbDat;

  always #5 clk = ~clk;

  serial_audio_xcvr #(.DIV(2)) dut_i (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .lenSel(lenSel),
    .txLeft(txLeft), .txRight(txRight), .txValid(txValid), .txReady(txReady),
    .sBclkOut(sBclkOut), .sWsOut(sWsOut), .sDataOut(sDataOut),
    .sBclkIn(sBclkIn), .sWsIn(sWsIn), .sDataIn(sDataIn),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );

  int nTests = 0, nFail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // receive log
  logic [19:0] logL [0:63];
  logic [19:0] logR [0:63];
  int rxCnt = 0;
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && rxValid) begin
      logL[rxCnt % 64] = rxLeft;
      logR[rxCnt % 64] = rxRight;
      rxCnt++;
      chk(!prevValid, "R9", "rxValid single-cycle", 64'(prevValid), 64'd0);
    end
    prevValid = rxValid;
  end

  function automatic int lenOf(input logic [1:0] s);
    return (s == 2'b00) ? 16 : (s == 2'b01) ? 18 : 20;
  endfunction

  function automatic logic [19:0] maskOf(input int l);
    return 20'((64'd1 << l) - 1);
  endfunction

  function automatic logic [63:0] expFrame(input logic f, input int l,
                                           input logic [19:0] wl, input logic [19:0] wr);
    logic [63:0] r;
    r = '0;
    for (int p = 0; p < 64; p++) begin
      int k;
      logic [19:0] w;
      k = p % 32;
      w = (p < 32) ? wl : wr;
      if (f == 1'b0 && k >= 1 && k <= l) r[p] = w[5'(l - k)];
      if (f == 1'b1 && (31 - k) < l)     r[p] = w[5'(31 - k)];
    end
    return r;
  endfunction

  task automatic waitRx(input int base);
    int n = 0;
    while (rxCnt <= base && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pushPair(input logic [19:0] l, input logic [19:0] r);
    while (!txReady) @(negedge clk);
    txLeft = l; txRight = r; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
  endtask

  task automatic testReset();
    chk(sBclkOut == 1'b0, "R1", "bclk in reset", 64'(sBclkOut), 64'd0);
    chk(sWsOut == 1'b1, "R1", "ws in reset", 64'(sWsOut), 64'd1);
    chk(sDataOut == 1'b0, "R1", "data in reset", 64'(sDataOut), 64'd0);
    chk(txReady == 1'b1, "R1", "ready in reset", 64'(txReady), 64'd1);
    chk(rxValid == 1'b0, "R1", "valid in reset", 64'(rxValid), 64'd0);
  endtask

  task automatic testPeriod();
    logic pv;
    int rises = 0, n = 0;
    pv = sBclkOut;
    while (rises < 2) begin
      @(negedge clk);
      if (rises == 1) n++;
      if (sBclkOut && !pv) rises++;
      pv = sBclkOut;
    end
    chk(n == 4, "R2", "bit clock period", 64'(n), 64'd4);
  endtask

  // one frame: checks bit placement, word select and loopback receive
  task automatic testFrame(input logic f, input logic [1:0] s,
                           input logic [19:0] wl, input logic [19:0] wr, input string req);
    logic [63:0] gotD, gotW, expD;
    int l, base;
    l = lenOf(s);
    fmtSel = f; lenSel = s;
    repeat (600) @(negedge clk);
    pushPair(wl, wr);
    chk(txReady == 1'b0, "R6", "ready low after accept", 64'(txReady), 64'd0);
    while (!txReady) @(negedge clk);
    for (int p = 0; p < 64; p++) begin
      @(posedge sBclkOut);
      gotD[p] = sDataOut;
      gotW[p] = sWsOut;
    end
    expD = expFrame(f, l, wl, wr);
    chk(gotD == expD, req, "serial frame bits", gotD, expD);
    chk(gotW == 64'hFFFFFFFF_00000000, "R2", "word select pattern", gotW, 64'hFFFFFFFF_00000000);
    base = rxCnt;
    waitRx(base);
    chk(rxCnt > base, "R9", "pair strobe seen", 64'(rxCnt), 64'(base + 1));
    chk(logL[base % 64] == (wl & maskOf(l)), "R8", "loopback left",
        64'(logL[base % 64]), 64'(wl & maskOf(l)));
    chk(logR[base % 64] == (wr & maskOf(l)), "R8", "loopback right",
        64'(logR[base % 64]), 64'(wr & maskOf(l)));
  endtask

  task automatic testStream();
    int base;
    fmtSel = 1'b0; lenSel = 2'b10;
    repeat (600) @(negedge clk);
    pushPair(20'h11111, 20'h22222);
    while (!txReady) @(negedge clk);
    base = rxCnt;
    pushPair(20'h33333, 20'h44444);
    chk(txReady == 1'b0, "R6", "second pair held off", 64'(txReady), 64'd0);
    pushPair(20'h55555, 20'h66666);
    repeat (1700) @(negedge clk);
    chk(rxCnt >= base + 5, "R9", "stream strobe count", 64'(rxCnt), 64'(base + 5));
    chk(logL[(base + 1) % 64] == 20'h11111 && logR[(base + 1) % 64] == 20'h22222, "R6",
        "stream pair 1", {logL[(base + 1) % 64], logR[(base + 1) % 64]}, {20'h11111, 20'h22222});
    chk(logL[(base + 2) % 64] == 20'h33333 && logR[(base + 2) % 64] == 20'h44444, "R6",
        "stream pair 2", {logL[(base + 2) % 64], logR[(base + 2) % 64]}, {20'h33333, 20'h44444});
    chk(logL[(base + 3) % 64] == 20'h55555 && logR[(base + 3) % 64] == 20'h66666, "R6",
        "stream pair 3", {logL[(base + 3) % 64], logR[(base + 3) % 64]}, {20'h55555, 20'h66666});
    chk(logL[(base + 4) % 64] == 20'h0 && logR[(base + 4) % 64] == 20'h0, "R7",
        "silent frame after underrun", {logL[(base + 4) % 64], logR[(base + 4) % 64]}, 64'd0);
  endtask

  task automatic driveBit(input logic ws, input logic d);
    @(negedge clk);
    tbBclk = 1'b0; tbWs = ws; tbDat = d;
    repeat (4) @(negedge clk);
    tbBclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // external stream with ones in every padding position
  task automatic testRxPadding(input logic f, input logic [1:0] s,
                               input logic [19:0] wl, input logic [19:0] wr);
    int l, base;
    l = lenOf(s);
    fmtSel = f; lenSel = s;
    useLoop = 1'b0;
    base = rxCnt;
    for (int fr = 0; fr < 3; fr++)
      for (int p = 0; p < 64; p++) begin
        int k;
        logic [19:0] w;
        logic b;
        k = p % 32;
        w = (p < 32) ? wl : wr;
        b = 1'b1;
        if (f == 1'b0 && k >= 1 && k <= l) b = w[5'(l - k)];
        if (f == 1'b1 && (31 - k) < l)     b = w[5'(31 - k)];
        driveBit(p >= 32, b);
      end
    driveBit(1'b0, 1'b1);
    driveBit(1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk(rxCnt > base, "R9", "external stream strobe", 64'(rxCnt), 64'(base + 1));
    chk(logL[(rxCnt - 1) % 64] == (wl & maskOf(l)) && logR[(rxCnt - 1) % 64] == (wr & maskOf(l)),
        "R8", "padding ignored", {logL[(rxCnt - 1) % 64], logR[(rxCnt - 1) % 64]},
        {wl & maskOf(l), wr & maskOf(l)});
    useLoop = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPeriod();
    testFrame(1'b0, 2'b00, 20'hFA5C3, 20'h31234, "R3");
    testFrame(1'b0, 2'b01, 20'h2B00D, 20'h0C0DE, "R3");
    testFrame(1'b0, 2'b10, 20'h8F00F, 20'h7ACE1, "R3");
    testFrame(1'b1, 2'b00, 20'hE9A5A, 20'hB5A5B, "R4");
    testFrame(1'b1, 2'b01, 20'h3FFFF, 20'h21001, "R4");
    testFrame(1'b1, 2'b11, 20'h80001, 20'h5EED5, "R5");
    testStream();
    testRxPadding(1'b0, 2'b01, 20'hF2345, 20'h1ABCD);
    testRxPadding(1'b1, 2'b00, 20'hF8421, 20'h0F0F0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog", "run did not complete", 64'd0, 64'd1);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule